// File: doc/BRIEF.md
# Per-Lane Word Skew Compensator

This block sits on one data lane of a multi-lane parallel receiver whose lanes reach the receiver with different whole-word skews. A separate reference lane, already aligned and framed upstream, carries periodic copies of every data lane's words. In each reference frame, each data lane owns a short run of consecutive sample words. The block delays its own lane's received words by a variable number of clock cycles. It searches that delay until the delayed lane words equal the samples of this lane that the reference lane carries. After that, the lane's output is aligned to the reference lane and to every other lane that has been tuned the same way.

Searching starts only while the reference framer reports lock. In every frame, the block compares the sample words at this lane's positions against the delayed lane words. A frame with any differing bit moves the delay one word further, and the delay wraps from its maximum back to zero. The first frame whose samples all agree freezes the delay. Once aligned, the block tolerates a programmable run of consecutive bad frames before it goes back to searching. A one-cycle pulse flags each compared word that differs.

Top module: `skew_lane_comp`

## Requirements
- R1: `lane_out` is registered: the value visible after clock edge t equals the `lane_word` sampled at edge t minus `dly_val` cycles (with `dly_val` = 0 it is the word sampled at edge t).
- R2: Only the SAMPLES words at frame positions from 4 + 4*(NUM_LANES-1-LANE_IDX) up to 3 above that (positions 44 to 47 with the defaults) are compared. A difference at any other `ref_pos` gives no pulse and does not count against the lane.
- R3: `miss_pulse` rises one cycle after each compared sample word whose value differs from the delayed lane word, and it stays high for exactly one cycle per such word.
- R4: While searching, a frame with at least one differing sample word increases `dly_val` by one in the cycle after the last frame position (`ref_pos` = 67). The value wraps from 127 to 0.
- R5: While searching, the first frame whose sample words all match puts the lane in the aligned state. While aligned, `dly_val` holds its value.
- R6: While aligned, BAD_FRAMES consecutive frames (default 4, range 1 to 64) that each contain a differing sample word return the lane to searching without changing `dly_val`. Any fully matching frame clears the run.
- R7: While `ref_locked` is low, nothing is compared, `miss_pulse` stays low and the lane returns to searching. A frame is judged only if `ref_locked` was high from its first sample word to its last position.
- R8: While `rst_n` is low, `dly_val`, `miss_pulse` and `lane_out` are all zero.
- R9: Once aligned to a steady lane, `miss_pulse` stays low for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lane_word | input | 16 | Raw received word of this data lane |
| ref_word | input | 16 | Aligned word of the reference lane |
| ref_pos | input | 7 | Position of `ref_word` within the 68-word frame |
| ref_locked | input | 1 | High while the reference framer is in frame |
| lane_out | output | 16 | Lane data after the inserted delay |
| dly_val | output | 7 | Inserted delay in words |
| miss_pulse | output | 1 | One-cycle flag for each differing sample word |

## Verification
The frame that uses up the bad-frame allowance in the aligned state and the first search step both act on `dly_val` at frame ends. A fault could move the delay on the exit frame itself, or it could fail to wrap. The bench makes these coincide at the boundary. It tunes the lane to a skew of 127 and then corrupts one sample word for four frames in a row, so the exit happens while the delay sits at 127. It then corrupts one more frame and expects `dly_val` to read 127 after the exit frame and 0 after the next one.

// File: rtl/skew_cmp_pkg.sv
package skew_cmp_pkg;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_MATCH  = 1'b1
  } lane_state_e;

endpackage

// File: rtl/skew_delay_line.sv
module skew_delay_line #(
  parameter int DATA_W = 16,
  parameter int DLY_W  = 7,
  localparam int DEPTH = 1 << DLY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic [DLY_W-1:0]  dly,
  output logic [DATA_W-1:0] dly_word,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] ring [DEPTH];
  logic [DLY_W-1:0]  wr_ptr_q;
  logic [DLY_W-1:0]  wr_ptr_d;
  logic [DLY_W-1:0]  rd_addr;
  logic [DATA_W-1:0] dout_q;

  // storage carries no reset: contents are valid once DEPTH words have passed
  always_ff @(posedge clk) begin
    ring[wr_ptr_q] <= din;
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q + 1'b1;
    rd_addr  = wr_ptr_q - dly;
    // zero delay bypasses the ring, whose slot still holds the oldest word
    dly_word = (dly == '0) ? din : ring[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      dout_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      dout_q   <= dly_word;
    end
  end

  assign dout = dout_q;

  p_zero_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dly == '0) |=> (dout == $past(din)));

endmodule

// File: rtl/skew_window_cmp.sv
module skew_window_cmp #(
  parameter int DATA_W      = 16,
  parameter int POS_W       = 7,
  parameter int WIN_START   = 44,
  parameter int SAMPLES     = 4,
  parameter int FRAME_WORDS = 68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked,
  input  logic [POS_W-1:0]  pos,
  input  logic [DATA_W-1:0] ref_word,
  input  logic [DATA_W-1:0] dly_word,
  output logic              frame_done,
  output logic              frame_bad,
  output logic              miss_pulse
);

  localparam logic [POS_W-1:0] WIN_LO  = POS_W'(WIN_START);
  localparam logic [POS_W-1:0] WIN_HI  = POS_W'(WIN_START + SAMPLES - 1);
  localparam logic [POS_W-1:0] POS_END = POS_W'(FRAME_WORDS - 1);

  logic in_win;
  logic win_first;
  logic at_end;
  logic word_miss;
  logic armed_q, armed_d;
  logic bad_q, bad_d;
  logic miss_q;

  always_comb begin
    in_win    = (pos >= WIN_LO) && (pos <= WIN_HI);
    win_first = (pos == WIN_LO);
    at_end    = (pos == POS_END);
    word_miss = locked && in_win && (dly_word != ref_word);

    armed_d = armed_q;
    bad_d   = bad_q;
    if (!locked) begin
      armed_d = 1'b0;
      bad_d   = 1'b0;
    end else if (win_first) begin
      armed_d = 1'b1;
      bad_d   = word_miss;
    end else if (at_end) begin
      armed_d = 1'b0;
      bad_d   = 1'b0;
    end else if (in_win) begin
      bad_d   = bad_q | word_miss;
    end

    frame_done = locked && at_end && (armed_q || win_first);
    frame_bad  = (win_first ? 1'b0 : bad_q) | word_miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      bad_q   <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      bad_q   <= bad_d;
      miss_q  <= word_miss;
    end
  end

  assign miss_pulse = miss_q;

  p_pulse_needs_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q |-> $past(locked));

  p_disarm_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !armed_q && !bad_q);

  p_pulse_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q |-> ($past(pos) >= WIN_LO) && ($past(pos) <= WIN_HI));

endmodule

// File: rtl/skew_search_ctrl.sv
module skew_search_ctrl
  import skew_cmp_pkg::*;
#(
  parameter int DLY_W      = 7,
  parameter int BAD_FRAMES = 4,
  localparam int CNT_W     = (BAD_FRAMES < 2) ? 1 : $clog2(BAD_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             locked,
  input  logic             frame_done,
  input  logic             frame_bad,
  output logic [DLY_W-1:0] dly,
  output lane_state_e      state
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BAD_FRAMES - 1);

  lane_state_e      state_q, state_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    cnt_d   = cnt_q;
    if (!locked) begin
      state_d = ST_SEARCH;
      cnt_d   = '0;
    end else if (frame_done) begin
      unique case (state_q)
        ST_SEARCH: begin
          if (frame_bad) begin
            dly_d = dly_q + 1'b1;
          end else begin
            state_d = ST_MATCH;
            cnt_d   = '0;
          end
        end
        ST_MATCH: begin
          if (!frame_bad) begin
            cnt_d = '0;
          end else if (cnt_q == CNT_LAST) begin
            state_d = ST_SEARCH;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      dly_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
      cnt_q   <= cnt_d;
    end
  end

  assign dly   = dly_q;
  assign state = state_q;

  p_dly_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dly_q) |-> (dly_q == DLY_W'($past(dly_q) + 1'b1)));

  p_dly_moves_searching_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dly_q) |-> ($past(state_q) == ST_SEARCH) && $past(frame_done));

  p_hold_when_matched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MATCH) |=> $stable(dly_q));

  p_run_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

  p_unlock_search_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> (state_q == ST_SEARCH) && (cnt_q == '0));

endmodule

// File: rtl/skew_lane_comp.sv
module skew_lane_comp
  import skew_cmp_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int DLY_W        = 7,
  parameter int NUM_LANES    = 16,
  parameter int LANE_IDX     = 5,
  parameter int HDR_WORDS    = 4,
  parameter int SAMPLES      = 4,
  parameter int BAD_FRAMES   = 4,
  parameter int RST_STAGES   = 2,
  localparam int FRAME_WORDS = HDR_WORDS + NUM_LANES * SAMPLES,
  localparam int POS_W       = $clog2(FRAME_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] lane_word,
  input  logic [DATA_W-1:0] ref_word,
  input  logic [POS_W-1:0]  ref_pos,
  input  logic              ref_locked,
  output logic [DATA_W-1:0] lane_out,
  output logic [DLY_W-1:0]  dly_val,
  output logic              miss_pulse
);

  // lanes are laid out highest index first after the header words
  localparam int WIN_START = HDR_WORDS + SAMPLES * (NUM_LANES - 1 - LANE_IDX);

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_core_n;
  logic [DATA_W-1:0]     dly_word;
  logic                  frame_done;
  logic                  frame_bad;
  lane_state_e           state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe_q[RST_STAGES-1];

  skew_delay_line #(
    .DATA_W(DATA_W),
    .DLY_W (DLY_W)
  ) u_line (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .din     (lane_word),
    .dly     (dly_val),
    .dly_word(dly_word),
    .dout    (lane_out)
  );

  skew_window_cmp #(
    .DATA_W     (DATA_W),
    .POS_W      (POS_W),
    .WIN_START  (WIN_START),
    .SAMPLES    (SAMPLES),
    .FRAME_WORDS(FRAME_WORDS)
  ) u_cmp (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .locked    (ref_locked),
    .pos       (ref_pos),
    .ref_word  (ref_word),
    .dly_word  (dly_word),
    .frame_done(frame_done),
    .frame_bad (frame_bad),
    .miss_pulse(miss_pulse)
  );

  skew_search_ctrl #(
    .DLY_W     (DLY_W),
    .BAD_FRAMES(BAD_FRAMES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .locked    (ref_locked),
    .frame_done(frame_done),
    .frame_bad (frame_bad),
    .dly       (dly_val),
    .state     (state)
  );

  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_core_n |-> (dly_val == '0) && !miss_pulse && (lane_out == '0));

  p_matched_quiet_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == ST_MATCH) && $past(state == ST_MATCH) && $past(ref_locked)
      && !$past(ref_locked && (ref_pos >= POS_W'(WIN_START))
                && (ref_pos < POS_W'(WIN_START + SAMPLES))
                && (dly_word != ref_word))
      |-> !miss_pulse);

endmodule

// File: tb/sim_skew_lane_comp.sv
module sim_skew_lane_comp;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 68;
  localparam int NONE       = 999;
  localparam int NVEC       = 5;
  // columns: injected skew, pulses in first searched frame, expected final delay
  localparam int VEC [NVEC][3] = '{
    '{0,   0, 0},
    '{1,   4, 1},
    '{9,   4, 9},
    '{40,  4, 40},
    '{127, 4, 127}
  };

  logic        clk;
  logic        rst_n;
  logic [15:0] lane_word;
  logic [15:0] ref_word;
  logic [6:0]  ref_pos;
  logic        ref_locked;
  logic [15:0] lane_out;
  logic [6:0]  dly_val;
  logic        miss_pulse;

  int checks;
  int errors;
  int cyc;
  int last_idx;
  int skew;
  int bad_pos;
  int pulses;
  bit lock;
  bit done;
  event frame_ev;

  skew_lane_comp u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_word (lane_word),
    .ref_word  (ref_word),
    .ref_pos   (ref_pos),
    .ref_locked(ref_locked),
    .lane_out  (lane_out),
    .dly_val   (dly_val),
    .miss_pulse(miss_pulse)
  );

  function automatic logic [15:0] pat(input int t);
    return 16'(t * 40503 + 4660);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // stream driver and pulse counter, all on the falling edge
  always @(negedge clk) begin
    int p;
    if (miss_pulse) pulses++;
    p = cyc % FRAME;
    lane_word  = pat(cyc);
    ref_word   = pat(cyc - skew) ^ ((p == bad_pos) ? 16'h0100 : 16'h0000);
    ref_pos    = 7'(p);
    ref_locked = lock;
    last_idx   = cyc;
    cyc++;
    if (p == 0) -> frame_ev;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; cyc = 0; pulses = 0; done = 0;
    skew = 0; bad_pos = NONE; lock = 0; rst_n = 1'b0;

    // table walk: reset, lock, search to the injected skew, verify steady state
    for (int v = 0; v < NVEC; v++) begin
      rst_n = 1'b0; lock = 0; bad_pos = NONE; skew = VEC[v][0];
      repeat (3) @(negedge clk);
      chk("R8 dly_val in reset", dly_val, 0);
      chk("R8 miss_pulse in reset", miss_pulse, 0);
      chk("R8 lane_out in reset", lane_out, 0);
      rst_n = 1'b1;
      repeat (3) @(frame_ev);
      lock = 1; pulses = 0;
      for (int k = 0; k <= VEC[v][0]; k++) begin
        @(frame_ev);
        if (k == 0) chk("R3 pulses in first searched frame", pulses, VEC[v][1]);
        pulses = 0;
      end
      chk("R5 delay after first clean frame", dly_val, VEC[v][2]);
      @(frame_ev);
      chk("R9 pulses while aligned", pulses, 0);
      chk("R1 lane_out delayed by dly_val", lane_out, pat(last_idx - 1 - VEC[v][0]));
      pulses = 0;
    end

    // window edges: words just outside this lane's samples are ignored
    bad_pos = 43; pulses = 0;
    @(frame_ev);
    chk("R2 word before window", pulses, 0);
    bad_pos = 48; pulses = 0;
    @(frame_ev);
    chk("R2 word after window", pulses, 0);
    chk("R2 delay untouched", dly_val, 127);

    // single bad word gives a single pulse; aligned lane keeps its delay
    bad_pos = 44; pulses = 0;
    @(frame_ev);
    chk("R3 one pulse for one bad word", pulses, 1);
    chk("R6 first bad frame tolerated", dly_val, 127);
    bad_pos = NONE;
    @(frame_ev);

    // three bad, one clean, three bad: run must have been cleared
    bad_pos = 47;
    repeat (3) @(frame_ev);
    chk("R6 three bad frames tolerated", dly_val, 127);
    bad_pos = NONE;
    @(frame_ev);
    bad_pos = 47;
    repeat (3) @(frame_ev);
    chk("R6 clean frame cleared the run", dly_val, 127);
    @(frame_ev);
    chk("R6 exit frame leaves delay", dly_val, 127);
    @(frame_ev);
    chk("R4 search step wraps 127 to 0", dly_val, 0);

    // re-search to a new skew
    skew = 2; bad_pos = NONE;
    @(frame_ev);
    chk("R4 search step", dly_val, 1);
    @(frame_ev);
    @(frame_ev);
    chk("R5 aligned at new skew", dly_val, 2);
    pulses = 0;
    @(frame_ev);
    chk("R9 pulses after realign", pulses, 0);

    // lock loss: no compare, then lane is searching again
    lock = 0; bad_pos = 44; pulses = 0;
    @(frame_ev);
    chk("R7 no pulse while unlocked", pulses, 0);
    chk("R7 delay held while unlocked", dly_val, 2);
    lock = 1; bad_pos = 45; pulses = 0;
    @(frame_ev);
    chk("R3 pulse after relock", pulses, 1);
    chk("R7 relock frame steps as search", dly_val, 3);
    skew = 3; bad_pos = NONE;
    @(frame_ev);
    chk("R5 aligned after relock", dly_val, 3);
    pulses = 0;
    @(frame_ev);
    chk("R9 quiet after relock", pulses, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule